// File: doc/BRIEF.md
# Block Address Translation Lookup

This block maps an effective address onto a physical address through a small set of block translation slots. Each slot is a pair of 32-bit words, an upper word and a lower word, held outside the block and presented on two flat buses. For each request the block scans the active slots in parallel. It checks the top address bits exactly and the block-length bits under a per-slot mask. It then picks the lowest-numbered valid match and returns a registered response: a hit flag, the physical address, the read, write and execute rights, and a fault flag for an access the rights do not allow.

A layout select input picks one of two slot layouts. In the standard layout, the length mask and both privilege validity bits live in the upper word, and a two-bit protection code lives in the lower word. In the legacy layout, the length mask and a single validity bit live in the lower word. The legacy protection code sits in the upper word and is read through a privilege-selected key. The parameter `ACTIVE_SLOTS` sets how many slots take part. A value of zero turns every request into a miss, so the caller falls back to its page-based path.

Top module: `bat_lookup`

## Requirements
- R1: While `rst_n` is low, every response output is 0.
- R2: A request sampled on a rising edge with `req_valid`=1 produces `rsp_valid`=1 after that edge. A cycle with `req_valid`=0 produces `rsp_valid`=0, `rsp_hit`=0, `rsp_fault`=0, zero rights and `rsp_pa`=0.
- R3: Standard layout (`alt_layout`=0): the mask is upper[12:2] applied to address bits [27:17]. A slot is valid when upper[1] is 1 for a supervisor request (`req_user`=0), or when upper[0] is 1 for a user request.
- R4: Standard layout rights come from lower[1:0]. Code 0 gives nothing. Code 2 gives read, write and execute. Codes 1 and 3 give read and execute.
- R5: Legacy layout (`alt_layout`=1): the mask is lower[5:0] applied to address bits [22:17], and address bits [27:23] are never masked. A slot is valid when lower[6] is 1, whatever the privilege.
- R6: Legacy layout rights use code upper[1:0] and a key. The key is upper[3] for supervisor requests and upper[2] for user requests. With key 0, codes 0 to 2 give read, write and execute, and code 3 gives read and execute. With key 1, code 0 gives nothing, code 2 gives read, write and execute, and codes 1 and 3 give read and execute.
- R7: A slot matches when address[31:28] equals upper[31:28], and address[27:17] with its masked bits cleared equals upper[27:17].
- R8: On a hit, `rsp_pa` is built from four parts. Bits [31:28] are lower[31:28]. Bits [27:17] are (address[27:17] AND mask) OR lower[27:17]. Bits [16:0] are the address bits [16:0].
- R9: When several valid slots match, the slot with the lowest index supplies the address and rights.
- R10: `req_acc` encodes 0 as fetch, 1 as load, 2 as store and 3 as load. `rsp_fault` is 1 only on a hit whose rights lack execute for a fetch, read for a load, or write for a store. On a miss, the fault flag, all rights and `rsp_pa` are 0.
- R11: Slots with an index of `ACTIVE_SLOTS` or above never hit. With `ACTIVE_SLOTS`=0, no request ever hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ea | input | 32 | Effective address |
| req_user | input | 1 | 1 for user privilege, 0 for supervisor |
| req_acc | input | 2 | Access kind (0 fetch, 1 load, 2 store, 3 load) |
| alt_layout | input | 1 | 0 selects the standard slot layout, 1 selects the legacy layout |
| bat_upper | input | NUM_SLOTS*32 | Upper words; slot i occupies bits [32i+31:32i] |
| bat_lower | input | NUM_SLOTS*32 | Lower words; slot i occupies bits [32i+31:32i] |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | A valid slot matched |
| rsp_pa | output | 32 | Translated physical address |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_ex | output | 1 | Execute granted |
| rsp_fault | output | 1 | Access kind not permitted by granted rights |

## Verification
The standard layout is swept over both validity bits, all four protection codes, both privileges and all four access kinds. This separates the privilege-to-validity routing and the rights table from the fault rule. The legacy layout is swept over its validity bit, both key bits, the protection code, privilege and access kind, which exposes any swap between the two keys. A mask sweep widens the length mask one bit at a time in both layouts, using addresses built to match and addresses drawn at random. It separates the masked compare from the address merge and shows the legacy mask stopping at bit 22. Overlapping slots with distinct physical bases, an idle cycle, and a second instance with no active slots confirm the lowest-index pick, the idle response and the slot-count limit.

// File: rtl/bat_lookup_pkg.sv
package bat_lookup_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned TAG_HI   = 31;
    localparam int unsigned TAG_LO   = 28;
    localparam int unsigned BLK_HI   = 27;
    localparam int unsigned BLK_LO   = 17;
    localparam int unsigned BLK_W    = BLK_HI - BLK_LO + 1;
    localparam int unsigned TAG_W    = TAG_HI - TAG_LO + 1;
    localparam int unsigned ALT_LEN_W = 6;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'b00,
        ACC_LOAD   = 2'b01,
        ACC_STORE  = 2'b10,
        ACC_LOAD_B = 2'b11
    } acc_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    typedef struct packed {
        logic             ok;
        logic [BLK_W-1:0] len_mask;
        perm_t            perm;
    } slot_attr_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [WORD_W-1:0] pa;
        perm_t             perm;
        logic              fault;
    } rsp_t;

    function automatic perm_t std_perm(input logic [1:0] code);
        perm_t p;
        p.rd = (code != 2'd0);
        p.ex = (code != 2'd0);
        p.wr = (code == 2'd2);
        return p;
    endfunction

    function automatic perm_t alt_perm(input logic key, input logic [1:0] code);
        perm_t p;
        if (!key) begin
            p.rd = 1'b1;
            p.ex = 1'b1;
            p.wr = (code != 2'd3);
        end else begin
            p.rd = (code != 2'd0);
            p.ex = (code != 2'd0);
            p.wr = (code == 2'd2);
        end
        return p;
    endfunction

endpackage

// File: rtl/bat_slot_decode.sv
module bat_slot_decode
    import bat_lookup_pkg::*;
(
    input  logic        alt_layout,
    input  logic        user,
    input  logic [12:0] upper_low,
    input  logic [6:0]  lower_low,
    output slot_attr_t  attr
);
    logic key;

    always_comb begin
        key  = user ? upper_low[2] : upper_low[3];
        attr = '0;
        if (!alt_layout) begin
            attr.len_mask = upper_low[12:2];
            attr.ok       = user ? upper_low[0] : upper_low[1];
            attr.perm     = std_perm(lower_low[1:0]);
        end else begin
            attr.len_mask = {{(BLK_W-ALT_LEN_W){1'b0}}, lower_low[ALT_LEN_W-1:0]};
            attr.ok       = lower_low[6];
            attr.perm     = alt_perm(key, upper_low[1:0]);
        end
    end
endmodule

// File: rtl/bat_slot_match.sv
module bat_slot_match
    import bat_lookup_pkg::*;
(
    input  logic [WORD_W-1:0] ea,
    input  logic [TAG_HI:BLK_LO] upper_hi,
    input  logic [TAG_HI:BLK_LO] lower_hi,
    input  slot_attr_t        attr,
    output logic              hit,
    output logic [WORD_W-1:0] pa
);
    logic             tag_eq;
    logic             blk_eq;
    logic [BLK_W-1:0] ea_blk;

    always_comb begin
        ea_blk = ea[BLK_HI:BLK_LO];
        tag_eq = (ea[TAG_HI:TAG_LO] == upper_hi[TAG_HI:TAG_LO]);
        blk_eq = ((ea_blk & ~attr.len_mask) == upper_hi[BLK_HI:BLK_LO]);
        hit    = attr.ok && tag_eq && blk_eq;
        pa     = {lower_hi[TAG_HI:TAG_LO],
                  (ea_blk & attr.len_mask) | lower_hi[BLK_HI:BLK_LO],
                  ea[BLK_LO-1:0]};
    end
endmodule

// File: rtl/bat_slot_pick.sv
module bat_slot_pick
    import bat_lookup_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS-1:0]             hit_i,
    input  logic [NUM_SLOTS-1:0][WORD_W-1:0] pa_i,
    input  perm_t [NUM_SLOTS-1:0]            perm_i,
    output logic                             hit_o,
    output logic [WORD_W-1:0]                pa_o,
    output perm_t                            perm_o
);
    always_comb begin
        hit_o  = 1'b0;
        pa_o   = '0;
        perm_o = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!hit_o && hit_i[i]) begin
                hit_o  = 1'b1;
                pa_o   = pa_i[i];
                perm_o = perm_i[i];
            end
        end
    end
endmodule

// File: rtl/bat_lookup.sv
module bat_lookup
    import bat_lookup_pkg::*;
#(
    parameter int unsigned NUM_SLOTS    = 4,
    parameter int unsigned ACTIVE_SLOTS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [31:0]                 req_ea,
    input  logic                        req_user,
    input  logic [1:0]                  req_acc,
    input  logic                        alt_layout,
    input  logic [NUM_SLOTS*32-1:0]     bat_upper,
    input  logic [NUM_SLOTS*32-1:0]     bat_lower,
    output logic                        rsp_valid,
    output logic                        rsp_hit,
    output logic [31:0]                 rsp_pa,
    output logic                        rsp_rd,
    output logic                        rsp_wr,
    output logic                        rsp_ex,
    output logic                        rsp_fault
);
    localparam int unsigned USED = (ACTIVE_SLOTS > NUM_SLOTS) ? NUM_SLOTS : ACTIVE_SLOTS;

    logic [NUM_SLOTS-1:0]             slot_hit;
    logic [NUM_SLOTS-1:0][WORD_W-1:0] slot_pa;
    perm_t [NUM_SLOTS-1:0]            slot_perm;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [WORD_W-1:0] up_w;
        logic [WORD_W-1:0] lo_w;
        slot_attr_t        attr;
        logic              raw_hit;
        logic              unused_fields;

        assign up_w = bat_upper[g*WORD_W +: WORD_W];
        assign lo_w = bat_lower[g*WORD_W +: WORD_W];
        assign unused_fields = ^{up_w[16:13], lo_w[16:7]};

        bat_slot_decode u_dec (
            .alt_layout (alt_layout),
            .user       (req_user),
            .upper_low  (up_w[12:0]),
            .lower_low  (lo_w[6:0]),
            .attr       (attr)
        );

        bat_slot_match u_match (
            .ea       (req_ea),
            .upper_hi (up_w[TAG_HI:BLK_LO]),
            .lower_hi (lo_w[TAG_HI:BLK_LO]),
            .attr     (attr),
            .hit      (raw_hit),
            .pa       (slot_pa[g])
        );

        assign slot_perm[g] = attr.perm;

        if (g < USED) begin : g_on
            assign slot_hit[g] = raw_hit;
        end else begin : g_off
            assign slot_hit[g] = 1'b0;
        end
    end

    logic              sel_hit;
    logic [WORD_W-1:0] sel_pa;
    perm_t             sel_perm;

    bat_slot_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .hit_i  (slot_hit),
        .pa_i   (slot_pa),
        .perm_i (slot_perm),
        .hit_o  (sel_hit),
        .pa_o   (sel_pa),
        .perm_o (sel_perm)
    );

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (sel_hit) begin
                rsp_d.hit  = 1'b1;
                rsp_d.pa   = sel_pa;
                rsp_d.perm = sel_perm;
                unique case (acc_e'(req_acc))
                    ACC_FETCH: rsp_d.fault = !sel_perm.ex;
                    ACC_STORE: rsp_d.fault = !sel_perm.wr;
                    default:   rsp_d.fault = !sel_perm.rd;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_pa    = rsp_q.pa;
    assign rsp_rd    = rsp_q.perm.rd;
    assign rsp_wr    = rsp_q.perm.wr;
    assign rsp_ex    = rsp_q.perm.ex;
    assign rsp_fault = rsp_q.fault;
endmodule

// File: rtl/bat_lookup_chk.sv
module bat_lookup_chk #(
    parameter int unsigned ACTIVE_SLOTS = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [31:0] rsp_pa,
    input logic        rsp_rd,
    input logic        rsp_wr,
    input logic        rsp_ex,
    input logic        rsp_fault
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));

    a_r10_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_hit);

    a_r10_miss_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_pa == 32'h0 && !rsp_rd && !rsp_wr && !rsp_ex));

    a_r6_write_implies_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr |-> (rsp_rd && rsp_ex));

    if (ACTIVE_SLOTS == 0) begin : g_none
        a_r11_zero_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
            !rsp_hit);
    end
endmodule

bind bat_lookup bat_lookup_chk #(.ACTIVE_SLOTS(ACTIVE_SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_pa    (rsp_pa),
    .rsp_rd    (rsp_rd),
    .rsp_wr    (rsp_wr),
    .rsp_ex    (rsp_ex),
    .rsp_fault (rsp_fault)
);

// File: tb/sim_bat_lookup.sv
`timescale 1ns/1ps
module sim_bat_lookup;
    localparam int NS  = 4;
    localparam int ACT = 3;

    typedef struct packed {
        logic        hit;
        logic [31:0] pa;
        logic        rd;
        logic        wr;
        logic        ex;
        logic        fault;
    } res_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic req_user = 1'b0;
    logic [1:0] req_acc = '0;
    logic alt_layout = 1'b0;
    logic [31:0] hi_a [NS];
    logic [31:0] lo_a [NS];
    logic [NS*32-1:0] up_bus, lo_bus;

    logic        v0, h0, r0, w0, x0, f0;
    logic [31:0] p0;
    logic        v1, h1, r1, w1, x1, f1;
    logic [31:0] p1;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rng = 32'h1badf00d;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            up_bus[i*32 +: 32] = hi_a[i];
            lo_bus[i*32 +: 32] = lo_a[i];
        end
    end

    bat_lookup #(.NUM_SLOTS(NS), .ACTIVE_SLOTS(ACT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
        .req_user(req_user), .req_acc(req_acc), .alt_layout(alt_layout),
        .bat_upper(up_bus), .bat_lower(lo_bus),
        .rsp_valid(v0), .rsp_hit(h0), .rsp_pa(p0), .rsp_rd(r0),
        .rsp_wr(w0), .rsp_ex(x0), .rsp_fault(f0));

    bat_lookup #(.NUM_SLOTS(NS), .ACTIVE_SLOTS(0)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
        .req_user(req_user), .req_acc(req_acc), .alt_layout(alt_layout),
        .bat_upper(up_bus), .bat_lower(lo_bus),
        .rsp_valid(v1), .rsp_hit(h1), .rsp_pa(p1), .rsp_rd(r1),
        .rsp_wr(w1), .rsp_ex(x1), .rsp_fault(f1));

    function automatic logic [31:0] rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    // Expected response computed from the requirement text
    function automatic res_t model(input logic [31:0] ea, input logic usr,
                                   input logic [1:0] acc, input logic alt, input int act);
        res_t r;
        r = '0;
        for (int i = 0; i < act; i++) begin
            logic [31:0] h, l;
            logic [10:0] m;
            logic v, key, rr, ww, xx;
            logic [1:0] code;
            h = hi_a[i];
            l = lo_a[i];
            if (!alt) begin
                m = h[12:2];
                v = usr ? h[0] : h[1];
                code = l[1:0];
                rr = code != 0; xx = rr; ww = code == 2;
            end else begin
                m = {5'b0, l[5:0]};
                v = l[6];
                key = usr ? h[2] : h[3];
                code = h[1:0];
                if (!key) begin rr = 1; xx = 1; ww = code != 3; end
                else begin rr = code != 0; xx = rr; ww = code == 2; end
            end
            if (!r.hit && v && ea[31:28] == h[31:28] && ((ea[27:17] & ~m) == h[27:17])) begin
                r.hit = 1'b1;
                r.pa = {l[31:28], (ea[27:17] & m) | l[27:17], ea[16:0]};
                r.rd = rr; r.wr = ww; r.ex = xx;
                r.fault = (acc == 2'd0) ? !xx : (acc == 2'd2) ? !ww : !rr;
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input res_t exp);
        res_t got;
        got = '{hit: h0, pa: p0, rd: r0, wr: w0, ex: x0, fault: f0};
        n_chk++;
        if (v0 !== 1'b1 || got !== exp) begin
            n_bad++;
            $display("FAIL %s: got v=%b hit=%b pa=%h rwx=%b%b%b flt=%b exp v=1 hit=%b pa=%h rwx=%b%b%b flt=%b",
                     tag, v0, got.hit, got.pa, got.rd, got.wr, got.ex, got.fault,
                     exp.hit, exp.pa, exp.rd, exp.wr, exp.ex, exp.fault);
        end
    endtask

    task automatic issue(input logic [31:0] ea, input logic usr, input logic [1:0] acc,
                         input logic alt, input string tag);
        res_t exp;
        req_ea = ea; req_user = usr; req_acc = acc; alt_layout = alt; req_valid = 1'b1;
        exp = model(ea, usr, acc, alt, ACT);
        @(posedge clk);
        @(negedge clk);
        check(tag, exp);
    endtask

    task automatic expect_bit(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b exp %b", tag, got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin hi_a[i] = '0; lo_a[i] = '0; end
        req_ea = 32'hffff_ffff;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset holds all outputs at zero
        expect_bit("R1 valid", v0, 1'b0);
        expect_bit("R1 any", |{h0, p0, r0, w0, x0, f0}, 1'b0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4/R10 standard layout sweep
        for (int vs = 0; vs < 2; vs++)
            for (int vu = 0; vu < 2; vu++)
                for (int pp = 0; pp < 4; pp++) begin
                    hi_a[0] = {4'h3, 11'h0AB, 4'h0, 11'h000, 1'(vs), 1'(vu)};
                    lo_a[0] = {4'h9, 11'h012, 15'h0, 2'(pp)};
                    for (int u = 0; u < 2; u++)
                        for (int a = 0; a < 4; a++)
                            issue({4'h3, 11'h0AB, 17'h0_5a5c}, 1'(u), 2'(a), 1'b0, "R3/R4/R10");
                end

        // R5/R6/R10 legacy layout sweep
        for (int v = 0; v < 2; v++)
            for (int k = 0; k < 4; k++)
                for (int pp = 0; pp < 4; pp++) begin
                    hi_a[0] = {4'h3, 11'h0AB, 13'h0, 2'(k), 2'(pp)};
                    lo_a[0] = {4'h9, 11'h012, 10'h0, 1'(v), 6'h00};
                    for (int u = 0; u < 2; u++)
                        for (int a = 0; a < 4; a++)
                            issue({4'h3, 11'h0AB, 17'h1_0f0f}, 1'(u), 2'(a), 1'b1, "R5/R6/R10");
                end

        // R7/R8 mask widths, standard layout
        for (int k = 0; k < 12; k++) begin
            logic [10:0] m;
            logic [31:0] b, ea;
            m = 11'((1 << k) - 1);
            b = rnd();
            hi_a[0] = {b[31:28], b[27:17] & ~m, 4'h0, m, 2'b11};
            lo_a[0] = {rnd() & 32'hfffe_0000} | 32'h2;
            for (int j = 0; j < 8; j++) begin
                ea = rnd();
                if (j % 2 == 0) ea = {b[31:28], (b[27:17] & ~m) | (ea[27:17] & m), ea[16:0]};
                else if (j == 3) ea[31:28] = b[31:28];
                issue(ea, 1'(j / 4), 2'(j), 1'b0, "R7/R8");
            end
        end

        // R5/R7/R8 mask widths, legacy layout (mask stops at bit 22)
        for (int k = 0; k < 7; k++) begin
            logic [5:0] m6;
            logic [10:0] m;
            logic [31:0] b, ea;
            m6 = 6'((1 << k) - 1);
            m = {5'b0, m6};
            b = rnd();
            hi_a[0] = {b[31:28], b[27:17] & ~m, 13'h0, 4'b0000};
            lo_a[0] = {rnd() & 32'hfffe_0000} | {25'h0, 1'b1, m6};
            for (int j = 0; j < 8; j++) begin
                ea = rnd();
                if (j % 2 == 0) ea = {b[31:28], (b[27:17] & ~m) | (ea[27:17] & m), ea[16:0]};
                else if (j == 3) ea = {b[31:28], b[27:17] ^ 11'h400, ea[16:0]};
                issue(ea, 1'(j / 4), 2'(j), 1'b1, "R5/R7/R8");
            end
        end

        // R9: overlapping slots, lowest index wins
        for (int i = 0; i < NS; i++) begin
            hi_a[i] = {4'h5, 11'h000, 4'h0, 11'h7ff, 2'b11};
            lo_a[i] = {4'(i + 1), 11'h000, 15'h0, 2'b10};
        end
        issue(32'h5123_4567, 1'b0, 2'd2, 1'b0, "R9");
        expect_bit("R9 slot0 base", p0[31:28] == 4'h1, 1'b1);
        hi_a[0][1:0] = 2'b00;
        issue(32'h5123_4567, 1'b0, 2'd1, 1'b0, "R9");
        expect_bit("R9 slot1 base", p0[31:28] == 4'h2, 1'b1);

        // R11: slot 3 lies beyond the active count
        hi_a[1][1:0] = 2'b00;
        hi_a[2][1:0] = 2'b00;
        issue(32'h5123_4567, 1'b0, 2'd1, 1'b0, "R11");
        expect_bit("R11 slot3 ignored", h0, 1'b0);
        hi_a[0][1:0] = 2'b11;
        issue(32'h5765_4321, 1'b1, 2'd0, 1'b0, "R11");
        expect_bit("R11 zero slots valid", v1, 1'b1);
        expect_bit("R11 zero slots miss", h1, 1'b0);
        expect_bit("R11 zero slots clean", |{p1, r1, w1, x1, f1}, 1'b0);

        // R2: idle cycle returns an empty response
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        expect_bit("R2 idle valid", v0, 1'b0);
        expect_bit("R2 idle empty", |{h0, p0, r0, w0, x0, f0}, 1'b0);
        issue(32'h5000_0000, 1'b0, 2'd2, 1'b0, "R2");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule